// File: doc/BRIEF.md
# Range-Matched Translation Buffer

This block is a small fully associative address translation buffer. Each entry describes one page by a virtual base address, a physical base address, a page size given as a power-of-two exponent, and a global flag. An address hits an entry when it lies in the half-open range that starts at the entry's virtual base and spans the page size. Pages of different sizes can coexist in the buffer.

A single request port carries an operation code, an address, a recency-update flag and the fields of a new entry. The operations are translate, install, flush everything, flush only the non-global entries, and remove the one entry that covers a given address. Exactly one operation is accepted per cycle. Translation results come back on a registered response one cycle later. Replacement follows an exact least-recently-used order that the hardware keeps as a compact age per valid entry. Installing an entry does not check it against entries already present. When several entries cover an address, the most recently used one wins.

Top module: `range_tlb`

## Requirements
- R1: Operation codes on `req_op`: 0 translate, 1 install, 2 flush all, 3 flush non-global, 4 remove. Codes 5 to 7 do nothing. An entry with virtual base B and exponent S covers address A when B <= A and A < B + 2^S, with the sum taken without wrap-around.
- R2: On a hit, the translated address is the entry's physical base OR-ed with the bits of A below bit S, that is A & (2^S - 1).
- R3: `rsp_valid` is 1 in the cycle after a translate request and 0 at all other times. On a miss `rsp_hit` is 0 and `rsp_paddr` is 0.
- R4: Install places the entry in an empty slot when one exists, and no valid entry is lost.
- R5: Install into a full buffer replaces the least recently used entry.
- R6: A newly installed entry becomes the most recently used.
- R7: A translate with `req_upd` = 1 that hits makes the hit entry the most recently used. With `req_upd` = 0 the order is left unchanged.
- R8: Flush all leaves every slot empty.
- R9: Flush non-global empties exactly the entries whose global flag is 0. Global entries stay valid and keep their translations.
- R10: Remove frees the entry that a translate of the same address would select, and does not change the order of the others.
- R11: When several entries cover an address, the most recently used one supplies the translation.
- R12: After reset the buffer is empty and `rsp_valid`, `rsp_hit` and `rsp_paddr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, one operation per cycle |
| req_op | input | 3 | Operation code (see R1) |
| req_addr | input | AW | Address to translate or remove, or the virtual base to install |
| req_upd | input | 1 | On translate, promote the hit entry to most recently used |
| ins_pbase | input | AW | Physical base of the entry to install |
| ins_shift | input | $clog2(AW) | Page size exponent of the entry to install |
| ins_global | input | 1 | Global flag of the entry to install |
| rsp_valid | output | 1 | Translation result valid |
| rsp_hit | output | 1 | Translation hit |
| rsp_paddr | output | AW | Translated address, 0 on a miss |

## Verification
The embedded properties check the following on every cycle: the response only follows a translate request, a hit never appears without a response, and the valid ages stay pairwise distinct. They also check the slot state that each flush leaves behind and that an install with free room adds exactly one valid slot. Whether the least recently used entry is the one evicted, the effect of the update flag, which of several overlapping entries wins, and the exact translated addresses can only be shown through sequences of operations. The bench therefore runs those sequences against a recency-ordered list model.

// File: rtl/range_tlb.sv
module range_tlb #(
  parameter int DEPTH = 16,
  parameter int AW    = 32,
  localparam int SW   = $clog2(AW),
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [2:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic          req_upd,
  input  logic [AW-1:0] ins_pbase,
  input  logic [SW-1:0] ins_shift,
  input  logic          ins_global,
  output logic          rsp_valid,
  output logic          rsp_hit,
  output logic [AW-1:0] rsp_paddr
);
  localparam logic [2:0] OP_XLATE = 3'd0, OP_INS = 3'd1, OP_FLUSH = 3'd2,
                         OP_FLUSH_NG = 3'd3, OP_REMOVE = 3'd4;
  localparam logic [IW-1:0] OLDEST = IW'(DEPTH - 1);
  localparam logic [AW:0]   ONE = 1;

  logic [DEPTH-1:0] vld, glb, match, keep, hit_oh;
  logic [AW-1:0]    vb [DEPTH];
  logic [AW-1:0]    pb [DEPTH];
  logic [SW-1:0]    sh [DEPTH];
  logic [IW-1:0]    age [DEPTH];
  logic [IW-1:0]    rank [DEPTH];

  logic          hit_any, free_any;
  logic [IW-1:0] hit_idx, free_idx, lru_idx, ins_idx, hit_age;
  logic [AW-1:0] hit_mask;

  wire do_xl  = req_valid && req_op == OP_XLATE;
  wire do_ins = req_valid && req_op == OP_INS;
  wire do_fa  = req_valid && req_op == OP_FLUSH;
  wire do_fng = req_valid && req_op == OP_FLUSH_NG;
  wire do_rm  = req_valid && req_op == OP_REMOVE;

  always_comb begin
    for (int i = 0; i < DEPTH; i++)
      match[i] = vld[i] && vb[i] <= req_addr &&
                 ({1'b0, vb[i]} + (ONE << sh[i])) > {1'b0, req_addr};
  end

  always_comb begin
    hit_any = 1'b0; hit_idx = '0; hit_age = '0;
    free_any = 1'b0; free_idx = '0; lru_idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (match[i] && (!hit_any || age[i] < hit_age)) begin
        hit_any = 1'b1; hit_idx = IW'(i); hit_age = age[i];
      end
      if (vld[i] && age[i] == OLDEST) lru_idx = IW'(i);
    end
    for (int i = DEPTH - 1; i >= 0; i--)
      if (!vld[i]) begin free_any = 1'b1; free_idx = IW'(i); end
  end

  assign ins_idx  = free_any ? free_idx : lru_idx;
  assign hit_mask = ~({AW{1'b1}} << sh[hit_idx]);

  always_comb begin
    hit_oh = '0;
    hit_oh[hit_idx] = hit_any;
    keep = do_rm ? (vld & ~hit_oh) : (vld & glb);
    for (int i = 0; i < DEPTH; i++) begin
      rank[i] = '0;
      for (int j = 0; j < DEPTH; j++)
        if (keep[j] && age[j] < age[i]) rank[i] = rank[i] + IW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0; glb <= '0;
      rsp_valid <= 1'b0; rsp_hit <= 1'b0; rsp_paddr <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        vb[i] <= '0; pb[i] <= '0; sh[i] <= '0; age[i] <= '0;
      end
    end else begin
      rsp_valid <= do_xl;
      rsp_hit   <= do_xl && hit_any;
      rsp_paddr <= (do_xl && hit_any) ? (pb[hit_idx] | (req_addr & hit_mask)) : '0;
      if (do_xl && req_upd && hit_any) begin
        for (int i = 0; i < DEPTH; i++)
          if (vld[i] && age[i] < hit_age) age[i] <= age[i] + IW'(1);
        age[hit_idx] <= '0;
      end
      if (do_ins) begin
        for (int i = 0; i < DEPTH; i++)
          if (vld[i] && age[i] != OLDEST) age[i] <= age[i] + IW'(1);
        vld[ins_idx] <= 1'b1;
        glb[ins_idx] <= ins_global;
        vb[ins_idx]  <= req_addr;
        pb[ins_idx]  <= ins_pbase;
        sh[ins_idx]  <= ins_shift;
        age[ins_idx] <= '0;
      end
      if (do_fa) vld <= '0;
      if (do_fng || do_rm) begin
        vld <= keep;
        for (int i = 0; i < DEPTH; i++) age[i] <= rank[i];
      end
    end
  end

  p_rsp_follows_xlate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && req_op == OP_XLATE));
  p_hit_needs_rsp_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_valid);
  p_flush_all_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == OP_FLUSH) |=> vld == '0);
  p_flush_ng_keeps_global_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == OP_FLUSH_NG) |=> vld == $past(vld & glb));
  p_install_no_loss_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == OP_INS && !(&vld)) |=>
      $countones(vld) == $countones($past(vld)) + 1);

  for (genvar a = 0; a < DEPTH; a++) begin : g_age_a
    for (genvar b = a + 1; b < DEPTH; b++) begin : g_age_b
      p_age_distinct_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (vld[a] && vld[b]) |-> age[a] != age[b]);
    end
  end
endmodule

// File: tb/range_tlb_tb_top.sv
module range_tlb_tb_top;
  localparam int D = 16;
  localparam int AW = 32;

  typedef struct packed {
    logic [31:0] vb;
    logic [31:0] pb;
    logic [4:0]  sh;
    logic        g;
  } ent_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_upd = 1'b0, ins_global = 1'b0;
  logic [2:0] req_op = 3'd0;
  logic [31:0] req_addr = '0, ins_pbase = '0;
  logic [4:0] ins_shift = '0;
  logic rsp_valid, rsp_hit;
  logic [31:0] rsp_paddr;

  int checks = 0, errors = 0;
  ent_t q[$];
  logic last_hit;
  logic [31:0] last_pa;

  always #5 clk = ~clk;

  range_tlb #(.DEPTH(D), .AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_upd(req_upd), .ins_pbase(ins_pbase),
    .ins_shift(ins_shift), .ins_global(ins_global),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_paddr(rsp_paddr));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int m_find(input logic [31:0] va);
    for (int k = 0; k < q.size(); k++)
      if (q[k].vb <= va && ({32'd0, q[k].vb} + (64'd1 << q[k].sh)) > {32'd0, va})
        return k;
    return -1;
  endfunction

  task automatic op(input logic [2:0] o, input logic [31:0] a, input bit upd,
                    input logic [31:0] p, input logic [4:0] s, input bit g, input string tag);
    int k;
    ent_t e;
    bit eh;
    logic [31:0] ep;
    req_valid = 1'b1; req_op = o; req_addr = a; req_upd = upd;
    ins_pbase = p; ins_shift = s; ins_global = g;
    k = m_find(a);
    @(negedge clk);
    req_valid = 1'b0;
    if (o == 3'd0) begin
      eh = (k >= 0);
      ep = eh ? (q[k].pb | (a & ~(32'hFFFF_FFFF << q[k].sh))) : 32'd0;
      chk(rsp_valid == 1'b1, {tag, " R3 rsp_valid"}, 32'(rsp_valid), 32'd1);
      chk(rsp_hit == eh, {tag, " R1 hit"}, 32'(rsp_hit), 32'(eh));
      chk(rsp_paddr == ep, {tag, " R2 paddr"}, rsp_paddr, ep);
      last_hit = rsp_hit; last_pa = rsp_paddr;
      if (upd && k > 0) begin e = q[k]; q.delete(k); q.push_front(e); end
    end else begin
      chk(rsp_valid == 1'b0, {tag, " R3 no rsp"}, 32'(rsp_valid), 32'd0);
      case (o)
        3'd1: begin
          e.vb = a; e.pb = p; e.sh = s; e.g = g;
          if (q.size() == D) void'(q.pop_back());
          q.push_front(e);
        end
        3'd2: q.delete();
        3'd3: for (int j = q.size() - 1; j >= 0; j--) if (!q[j].g) q.delete(j);
        3'd4: if (k >= 0) q.delete(k);
        default: ;
      endcase
    end
  endtask

  task automatic xl(input logic [31:0] a, input bit upd, input string tag);
    op(3'd0, a, upd, 32'd0, 5'd0, 1'b0, tag);
  endtask
  task automatic ins(input logic [31:0] a, input logic [31:0] p, input logic [4:0] s, input bit g);
    op(3'd1, a, 1'b0, p, s, g, "install");
  endtask
  task automatic fill();
    op(3'd2, 32'd0, 1'b0, 32'd0, 5'd0, 1'b0, "flush");
    for (int i = 0; i < D; i++) ins(32'(i) << 12, 32'h8000_0000 | (32'(i) << 16), 5'd12, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(rsp_valid == 0 && rsp_hit == 0 && rsp_paddr == 0, "R12 reset outputs", {rsp_valid, rsp_hit, rsp_paddr[29:0]}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    xl(32'h0000_1234, 1'b0, "R12 empty after reset");
    chk(last_hit == 0, "R12 miss after reset", 32'(last_hit), 32'd0);

    // R1/R2 range boundaries and offset merge
    ins(32'h0000_4000, 32'hABC0_0000, 5'd12, 1'b0);
    xl(32'h0000_4000, 1'b0, "R1 low edge");
    chk(last_hit == 1, "R1 low edge hit", 32'(last_hit), 32'd1);
    xl(32'h0000_4FFF, 1'b0, "R1 high edge");
    chk(last_pa == 32'hABC0_0FFF, "R2 high edge paddr", last_pa, 32'hABC0_0FFF);
    xl(32'h0000_5000, 1'b0, "R1 past end");
    chk(last_hit == 0, "R1 past end miss", 32'(last_hit), 32'd0);
    xl(32'h0000_3FFF, 1'b0, "R1 below base");
    chk(last_hit == 0, "R1 below base miss", 32'(last_hit), 32'd0);
    op(3'd6, 32'h0000_4000, 1'b0, 32'd0, 5'd0, 1'b0, "R1 unused code");
    xl(32'h0000_4010, 1'b0, "R1 unused code no effect");
    chk(last_hit == 1, "R1 unused code keeps entry", 32'(last_hit), 32'd1);

    // R4/R5 fill then overflow evicts LRU
    fill();
    for (int i = 0; i < D; i++) xl((32'(i) << 12) + 32'h34, 1'b0, "R4 all kept");
    ins(32'h0010_0000, 32'h1234_0000, 5'd12, 1'b0);
    xl(32'h0000_0034, 1'b0, "R5 oldest evicted");
    chk(last_hit == 0, "R5 oldest evicted miss", 32'(last_hit), 32'd0);
    xl(32'h0000_1034, 1'b0, "R5 next kept");
    chk(last_hit == 1, "R5 second oldest kept", 32'(last_hit), 32'd1);
    ins(32'h0011_0000, 32'h2234_0000, 5'd12, 1'b0);
    xl(32'h0010_0008, 1'b0, "R6 new entry survives");
    chk(last_hit == 1, "R6 new entry is MRU", 32'(last_hit), 32'd1);
    xl(32'h0000_1034, 1'b0, "R6 second evicted");
    chk(last_hit == 0, "R6 older entry evicted", 32'(last_hit), 32'd0);

    // R7 update flag
    fill();
    xl(32'h0000_0010, 1'b1, "R7 promote");
    ins(32'h0020_0000, 32'h3000_0000, 5'd12, 1'b0);
    xl(32'h0000_0010, 1'b0, "R7 promoted kept");
    chk(last_hit == 1, "R7 promoted entry kept", 32'(last_hit), 32'd1);
    fill();
    xl(32'h0000_0010, 1'b0, "R7 no promote");
    ins(32'h0020_0000, 32'h3000_0000, 5'd12, 1'b0);
    xl(32'h0000_0010, 1'b0, "R7 unpromoted evicted");
    chk(last_hit == 0, "R7 unpromoted entry evicted", 32'(last_hit), 32'd0);

    // R8 flush all
    op(3'd2, 32'd0, 1'b0, 32'd0, 5'd0, 1'b0, "R8 flush");
    xl(32'h0000_2000, 1'b0, "R8 after flush");
    chk(last_hit == 0, "R8 flushed miss", 32'(last_hit), 32'd0);

    // R9 flush non-global
    ins(32'h0000_8000, 32'h0100_0000, 5'd12, 1'b1);
    ins(32'h0000_9000, 32'h0200_0000, 5'd12, 1'b0);
    op(3'd3, 32'd0, 1'b0, 32'd0, 5'd0, 1'b0, "R9 flush ng");
    xl(32'h0000_8004, 1'b0, "R9 global");
    chk(last_pa == 32'h0100_0004, "R9 global kept", last_pa, 32'h0100_0004);
    xl(32'h0000_9004, 1'b0, "R9 nonglobal");
    chk(last_hit == 0, "R9 nonglobal gone", 32'(last_hit), 32'd0);

    // R11 overlap, R10 remove
    ins(32'h0004_0000, 32'h0A00_0000, 5'd16, 1'b0);
    ins(32'h0004_1000, 32'h0B00_0000, 5'd12, 1'b0);
    xl(32'h0004_1020, 1'b0, "R11 overlap");
    chk(last_pa == 32'h0B00_0020, "R11 newest wins", last_pa, 32'h0B00_0020);
    op(3'd4, 32'h0004_1020, 1'b0, 32'd0, 5'd0, 1'b0, "R10 remove");
    xl(32'h0004_1020, 1'b0, "R10 after remove");
    chk(last_pa == 32'h0A00_1020, "R10 older entry exposed", last_pa, 32'h0A00_1020);
    xl(32'h0000_8000, 1'b0, "R10 others kept");
    chk(last_hit == 1, "R10 unrelated entry kept", 32'(last_hit), 32'd1);

    // random mix
    void'($urandom(32'd1234));
    for (int n = 0; n < 4000; n++) begin
      int r;
      logic [4:0] s;
      logic [31:0] a;
      r = int'($urandom_range(0, 99));
      s = 5'($urandom_range(4, 12));
      a = $urandom & 32'h0000_FFFF;
      if (r < 55) xl(a, 1'($urandom), "R11 random xlate");
      else if (r < 88) ins(a, $urandom & (32'hFFFF_FFFF << s), s, 1'($urandom));
      else if (r < 95) op(3'd4, a, 1'b0, 32'd0, 5'd0, 1'b0, "R10 random remove");
      else if (r < 98) op(3'd3, a, 1'b0, 32'd0, 5'd0, 1'b0, "R9 random flush ng");
      else op(3'd2, a, 1'b0, 32'd0, 5'd0, 1'b0, "R8 random flush");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule